// File: doc/BRIEF.md
# Ping-pong IN endpoint transmit buffer

This block manages the transmit side of one IN endpoint: bulk, interrupt or isochronous. Firmware writes packet bytes into a load slot and then marks the packet ready. Marking can also happen on its own, once a packet reaches the configured maximum size. The block holds one packet, or two when double buffering is on. When the host sends an IN token, the block answers with the oldest packet, a NAK, a STALL or a zero-length packet. It also keeps the DATA0/DATA1 toggle that goes with each data packet.

Bytes leave as a stream, one per clock, together with a response code and the toggle. Serialization and CRC belong to a later stage. A three-state machine drives the bus side:

- IDLE waits for a token.
- STREAM sends bytes.
- AWAIT holds a sent bulk packet until the host acknowledges it.

The transitions are:

- *grant*: IDLE or AWAIT to STREAM when a token finds an eligible packet of one byte or more.
- *empty grant*: from a zero-length packet, directly to AWAIT (bulk) or to IDLE (isochronous).
- *bulk end*: STREAM to AWAIT.
- *iso end*: STREAM to IDLE, releasing the slot.
- *acked*: AWAIT to IDLE, releasing the slot.
- *abandon*: AWAIT to IDLE on a flush.
- *refuse*: IDLE or AWAIT to IDLE after a NAK, STALL or zero-length answer.
- A second token in AWAIT retransmits the packet through *grant*.

Top module: `inep_tx_ctrl`

## Requirements
- R1: After reset, tx_resp is 0, tx_valid, tx_pid1, st_in_rdy, st_pkt_present, st_sent_stall, st_underrun and irq are all 0.
- R2: With cfg_dbl low, a fw_set_rdy pulse commits the bytes written so far as one packet. st_in_rdy then reads 1 until that packet is released. Byte writes made while st_in_rdy is 1 are dropped.
- R3: With cfg_dbl high, st_in_rdy stays 0 after a commit while the other slot is free, and reads 1 only while two packets are held. Packets are sent in commit order.
- R4: st_pkt_present is 1 exactly while at least one committed packet is held.
- R5: With cfg_auto_set high and cfg_max_units nonzero, writing the byte that brings the load slot to cfg_max_units*8 bytes commits the packet without fw_set_rdy. Shorter packets wait for fw_set_rdy.
- R6: An IN token that finds an eligible packet gives tx_resp = 1 (DATA) in the following cycle. From that same cycle the bytes appear, one per cycle, with tx_valid, and tx_last marks the final byte. A zero-length packet gives DATA with no tx_valid.
- R7: In bulk mode the packet is released only on bus_ack after it has been sent, and a new token before that ACK resends it with the same toggle. irq pulses for one cycle right after each release when cfg_irq_en is high.
- R8: A token that finds no packet gives NAK (tx_resp = 3) in bulk mode and a zero-length answer (tx_resp = 2) in isochronous mode, and sets st_underrun in both. An isochronous packet is released, and the toggle flipped, at the end of its data without an ACK.
- R9: In isochronous mode with cfg_wait_sof high, a held packet becomes eligible only after a bus_sof pulse seen while it is held. A token before that gets tx_resp = 2 and leaves st_underrun unchanged.
- R10: In bulk mode with cfg_send_stall high, a token gets tx_resp = 4 (STALL). The same edge sets st_sent_stall, discards every held and partial packet, and clears st_in_rdy.
- R11: fw_flush (outside STREAM) discards only the oldest held packet and the partial load. Two flushes empty a slot pair holding two packets.
- R12: fw_clr_tog sets tx_pid1 to 0. Otherwise the toggle flips on each bulk ACK, or at the end of each packet when cfg_force_tog is high or in isochronous mode.
- R13: st_sent_stall and st_underrun stay set until a fw_clr_flags pulse clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_dbl | input | 1 | two-slot buffering |
| cfg_iso | input | 1 | isochronous mode |
| cfg_auto_set | input | 1 | commit on reaching maximum size |
| cfg_wait_sof | input | 1 | isochronous packet waits for SOF |
| cfg_force_tog | input | 1 | flip toggle after every packet |
| cfg_send_stall | input | 1 | answer tokens with STALL (bulk) |
| cfg_irq_en | input | 1 | interrupt enable |
| cfg_max_units | input | 8 | maximum packet size in 8-byte units |
| fw_wr_en | input | 1 | firmware byte write |
| fw_wr_data | input | 8 | firmware byte |
| fw_set_rdy | input | 1 | commit load slot |
| fw_flush | input | 1 | discard oldest packet |
| fw_clr_tog | input | 1 | reset toggle to DATA0 |
| fw_clr_flags | input | 1 | clear stall and underrun flags |
| bus_in_tok | input | 1 | IN token received |
| bus_ack | input | 1 | ACK received |
| bus_sof | input | 1 | SOF received |
| tx_resp | output | 3 | 0 none, 1 DATA, 2 zero-length, 3 NAK, 4 STALL |
| tx_valid | output | 1 | data byte valid |
| tx_data | output | 8 | data byte |
| tx_last | output | 1 | final byte of packet |
| tx_pid1 | output | 1 | data toggle (1 = DATA1) |
| st_in_rdy | output | 1 | load slot holds a committed packet |
| st_pkt_present | output | 1 | at least one packet held |
| st_sent_stall | output | 1 | STALL was sent |
| st_underrun | output | 1 | token found no packet |
| irq | output | 1 | packet-released pulse |

## Verification
The bench targets four corner cases.

- A lost ACK: a design that freed the slot at the end of the data would answer the retry with NAK or the wrong packet.
- Double buffering: a wrong slot pointer would raise st_in_rdy after one packet, or send the second packet first.
- Isochronous waiting: a token before SOF must get a zero-length answer without underrun, and the held packet must still go out later.
- Stall and flush must each remove exactly the right packets, and the auto-commit must fire at exactly the size limit and not one byte early.

// File: rtl/inep_pkg.sv
package inep_pkg;
    typedef enum logic [2:0] {
        RSP_NONE  = 3'd0,
        RSP_DATA  = 3'd1,
        RSP_ZLP   = 3'd2,
        RSP_NAK   = 3'd3,
        RSP_STALL = 3'd4
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_AWAIT  = 2'd2
    } st_e;
endpackage

// File: rtl/inep_slots.sv
module inep_slots #(
    parameter int SLOT_BYTES = 64,
    parameter int UNIT_W     = 8,
    localparam int LEN_W     = $clog2(SLOT_BYTES + 1),
    localparam int IDX_W     = $clog2(SLOT_BYTES),
    localparam int MAXB_W    = UNIT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbl,
    input  logic              auto_set,
    input  logic [UNIT_W-1:0] max_units,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              set_rdy,
    input  logic              flush,
    input  logic              wipe,
    input  logic              release_i,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              in_rdy,
    output logic              pkt_present,
    output logic              head_full,
    output logic [LEN_W-1:0]  head_len,
    output logic [7:0]        rd_byte
);
    logic [1:0]       full_q, full_n;
    logic             ld_q, rd_q;
    logic [LEN_W-1:0] wcnt_q, fill;
    logic [LEN_W-1:0] len_q [2];
    logic [7:0]       mem [2][SLOT_BYTES];
    logic [MAXB_W-1:0] max_bytes;
    logic wr_ok, auto_hit, commit, flush_hit;

    assign max_bytes = {max_units, 3'b000};
    assign wr_ok     = wr_en && !full_q[ld_q] && (wcnt_q < LEN_W'(SLOT_BYTES));
    assign fill      = wcnt_q + LEN_W'(wr_ok);
    assign auto_hit  = auto_set && wr_ok && (max_bytes != '0) && (32'(fill) == 32'(max_bytes));
    assign commit    = !wipe && !full_q[ld_q] && (set_rdy || auto_hit);
    assign flush_hit = flush && full_q[rd_q];

    always_comb begin
        full_n = full_q;
        if (commit) full_n[ld_q] = 1'b1;
        if (release_i || flush_hit) full_n[rd_q] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            full_q <= '0;
            ld_q   <= 1'b0;
            rd_q   <= 1'b0;
            wcnt_q <= '0;
            for (int s = 0; s < 2; s++) len_q[s] <= '0;
        end else begin
            full_q <= full_n;
            if (commit) len_q[ld_q] <= fill;
            if (commit || flush) wcnt_q <= '0;
            else if (wr_ok)      wcnt_q <= fill;
            rd_q <= dbl ? (rd_q ^ (release_i || flush_hit)) : 1'b0;
            ld_q <= dbl ? (ld_q ^ (full_n[ld_q] && !full_n[~ld_q])) : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[ld_q][wcnt_q[IDX_W-1:0]] <= wr_data;
    end

    assign in_rdy      = full_q[ld_q];
    assign pkt_present = |full_q;
    assign head_full   = full_q[rd_q];
    assign head_len    = len_q[rd_q];
    assign rd_byte     = mem[rd_q][rd_idx];

    // R7: the state machine only releases a slot that actually holds a packet
    a_r7_release_has_packet: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> head_full);
endmodule

// File: rtl/inep_txfsm.sv
module inep_txfsm
    import inep_pkg::*;
#(
    parameter int SLOT_BYTES = 64,
    localparam int LEN_W     = $clog2(SLOT_BYTES + 1),
    localparam int IDX_W     = $clog2(SLOT_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iso,
    input  logic             send_stall,
    input  logic             wait_sof,
    input  logic             force_tog,
    input  logic             clr_tog,
    input  logic             flush_req,
    input  logic             clr_flags,
    input  logic             irq_en,
    input  logic             in_tok,
    input  logic             ack,
    input  logic             sof,
    input  logic             head_full,
    input  logic [LEN_W-1:0] head_len,
    output rsp_e             resp,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             tx_pid1,
    output logic [IDX_W-1:0] rd_idx,
    output logic             release_o,
    output logic             flush_o,
    output logic             wipe_o,
    output logic             sent_stall,
    output logic             underrun,
    output logic             irq
);
    st_e              st_q, st_n;
    rsp_e             resp_q, rsp_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic [LEN_W-1:0] len_q, len_n;
    logic tog_q, ss_q, ur_q, irq_q, sof_ok_q;
    logic rel, flip, wipe, ss_set, ur_set, done, eligible, at_last;

    assign eligible = head_full && (!iso || !wait_sof || sof_ok_q);
    assign at_last  = (idx_q == IDX_W'(len_q - 1'b1));
    assign flush_o  = flush_req && (st_q != ST_STREAM);

    always_comb begin
        st_n = st_q; rsp_n = RSP_NONE; idx_n = idx_q; len_n = len_q;
        rel = 1'b0; flip = 1'b0; wipe = 1'b0; ss_set = 1'b0; ur_set = 1'b0; done = 1'b0;
        unique case (st_q)
            ST_STREAM: begin
                if (at_last) done = 1'b1;
                else         idx_n = idx_q + 1'b1;
            end
            ST_IDLE, ST_AWAIT: begin
                if (st_q == ST_AWAIT && ack) begin
                    rel = 1'b1; flip = !force_tog; st_n = ST_IDLE;
                end else if (in_tok) begin
                    if (!iso && send_stall) begin
                        rsp_n = RSP_STALL; ss_set = 1'b1; wipe = 1'b1; st_n = ST_IDLE;
                    end else if (eligible) begin
                        rsp_n = RSP_DATA; len_n = head_len; idx_n = '0;
                        if (head_len == '0) done = 1'b1;
                        else                st_n = ST_STREAM;
                    end else if (iso) begin
                        rsp_n = RSP_ZLP; ur_set = !head_full; st_n = ST_IDLE;
                    end else begin
                        rsp_n = RSP_NAK; ur_set = 1'b1; st_n = ST_IDLE;
                    end
                end else if (flush_req) begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (done) begin
            idx_n = '0;
            if (iso) begin rel = 1'b1; flip = 1'b1; st_n = ST_IDLE; end
            else     begin flip = force_tog; st_n = ST_AWAIT; end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE; resp_q <= RSP_NONE; idx_q <= '0; len_q <= '0;
            tog_q <= 1'b0; ss_q <= 1'b0; ur_q <= 1'b0; irq_q <= 1'b0; sof_ok_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            resp_q <= rsp_n;
            idx_q  <= idx_n;
            len_q  <= len_n;
            tog_q  <= clr_tog ? 1'b0 : (tog_q ^ flip);
            ss_q   <= ss_set | (ss_q & ~clr_flags);
            ur_q   <= ur_set | (ur_q & ~clr_flags);
            irq_q  <= rel & irq_en;
            if (rel || wipe || flush_o) sof_ok_q <= 1'b0;
            else if (sof && head_full)  sof_ok_q <= 1'b1;
        end
    end

    always_comb begin
        resp       = resp_q;
        tx_valid   = (st_q == ST_STREAM);
        tx_last    = (st_q == ST_STREAM) && at_last;
        tx_pid1    = tog_q;
        rd_idx     = idx_q;
        release_o  = rel;
        wipe_o     = wipe;
        sent_stall = ss_q;
        underrun   = ur_q;
        irq        = irq_q;
    end

    // R8: a NAK answer is always accompanied by the underrun flag
    a_r8_nak_sets_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_q == RSP_NAK) |-> ur_q);
    // R12: the toggle does not move while a packet is being streamed
    a_r12_pid_stable_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STREAM && $past(st_q == ST_STREAM) && !$past(clr_tog)) |-> $stable(tog_q));
endmodule

// File: rtl/inep_tx_ctrl.sv
module inep_tx_ctrl #(
    parameter int SLOT_BYTES = 64,
    parameter int UNIT_W     = 8,
    localparam int LEN_W     = $clog2(SLOT_BYTES + 1),
    localparam int IDX_W     = $clog2(SLOT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dbl,
    input  logic              cfg_iso,
    input  logic              cfg_auto_set,
    input  logic              cfg_wait_sof,
    input  logic              cfg_force_tog,
    input  logic              cfg_send_stall,
    input  logic              cfg_irq_en,
    input  logic [UNIT_W-1:0] cfg_max_units,
    input  logic              fw_wr_en,
    input  logic [7:0]        fw_wr_data,
    input  logic              fw_set_rdy,
    input  logic              fw_flush,
    input  logic              fw_clr_tog,
    input  logic              fw_clr_flags,
    input  logic              bus_in_tok,
    input  logic              bus_ack,
    input  logic              bus_sof,
    output logic [2:0]        tx_resp,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_pid1,
    output logic              st_in_rdy,
    output logic              st_pkt_present,
    output logic              st_sent_stall,
    output logic              st_underrun,
    output logic              irq
);
    inep_pkg::rsp_e   resp;
    logic             head_full, release_s, flush_s, wipe_s;
    logic [LEN_W-1:0] head_len;
    logic [IDX_W-1:0] rd_idx;

    inep_slots #(.SLOT_BYTES(SLOT_BYTES), .UNIT_W(UNIT_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .dbl(cfg_dbl), .auto_set(cfg_auto_set),
        .max_units(cfg_max_units), .wr_en(fw_wr_en), .wr_data(fw_wr_data),
        .set_rdy(fw_set_rdy), .flush(flush_s), .wipe(wipe_s), .release_i(release_s),
        .rd_idx(rd_idx), .in_rdy(st_in_rdy), .pkt_present(st_pkt_present),
        .head_full(head_full), .head_len(head_len), .rd_byte(tx_data)
    );

    inep_txfsm #(.SLOT_BYTES(SLOT_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .iso(cfg_iso), .send_stall(cfg_send_stall),
        .wait_sof(cfg_wait_sof), .force_tog(cfg_force_tog), .clr_tog(fw_clr_tog),
        .flush_req(fw_flush), .clr_flags(fw_clr_flags), .irq_en(cfg_irq_en),
        .in_tok(bus_in_tok), .ack(bus_ack), .sof(bus_sof), .head_full(head_full),
        .head_len(head_len), .resp(resp), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_pid1(tx_pid1), .rd_idx(rd_idx), .release_o(release_s), .flush_o(flush_s),
        .wipe_o(wipe_s), .sent_stall(st_sent_stall), .underrun(st_underrun), .irq(irq)
    );

    assign tx_resp = resp;

    // R10: after a STALL answer no packet remains held
    a_r10_stall_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_resp == 3'd4) |-> !st_pkt_present);
    // R6: bytes are only streamed from a held packet
    a_r6_data_needs_packet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> st_pkt_present);
endmodule

// File: tb/inep_tx_ctrl_tb.sv
`timescale 1ns/1ps
module inep_tx_ctrl_tb;
    localparam int SLOT = 64;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic cfg_dbl = 0, cfg_iso = 0, cfg_auto_set = 0, cfg_wait_sof = 0;
    logic cfg_force_tog = 0, cfg_send_stall = 0, cfg_irq_en = 1;
    logic [7:0] cfg_max_units = 8'd1;
    logic fw_wr_en = 0, fw_set_rdy = 0, fw_flush = 0, fw_clr_tog = 0, fw_clr_flags = 0;
    logic [7:0] fw_wr_data = '0;
    logic bus_in_tok = 0, bus_ack = 0, bus_sof = 0;
    logic [2:0] tx_resp;
    logic tx_valid, tx_last, tx_pid1, st_in_rdy, st_pkt_present, st_sent_stall, st_underrun, irq;
    logic [7:0] tx_data;

    inep_tx_ctrl u_dut (.*);

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0;

    // behavioural reference model
    int m_len[$];
    logic [7:0] m_dat[$];
    logic [7:0] m_ld[$];
    int m_st = 0, m_pos = 0, m_cur = 0, m_resp = 0, sz = 0;
    bit m_tog = 0, m_ss = 0, m_ur = 0, m_irq = 0, m_sofok = 0;
    bit rdy_old, rel, flip, wipe, fl, acc, commit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_len.delete(); m_dat.delete(); m_ld.delete();
            m_st = 0; m_pos = 0; m_cur = 0; m_resp = 0;
            m_tog = 0; m_ss = 0; m_ur = 0; m_irq = 0; m_sofok = 0;
        end else begin
            sz = m_len.size();
            rdy_old = cfg_dbl ? (sz == 2) : (sz == 1);
            rel = 0; flip = 0; wipe = 0; m_resp = 0;
            fl = fw_flush && (m_st != 1);
            if (fw_clr_flags) begin m_ss = 0; m_ur = 0; end
            if (m_st == 1) begin
                if (m_pos == m_cur - 1) begin
                    m_pos = 0;
                    if (cfg_iso) begin rel = 1; flip = 1; m_st = 0; end
                    else begin flip = cfg_force_tog; m_st = 2; end
                end else m_pos++;
            end else if (m_st == 2 && bus_ack) begin
                rel = 1; flip = !cfg_force_tog; m_st = 0;
            end else if (bus_in_tok) begin
                if (!cfg_iso && cfg_send_stall) begin
                    m_resp = 4; m_ss = 1; wipe = 1; m_st = 0;
                end else if (sz > 0 && (!cfg_iso || !cfg_wait_sof || m_sofok)) begin
                    m_resp = 1; m_cur = m_len[0]; m_pos = 0;
                    if (m_cur == 0) begin
                        if (cfg_iso) begin rel = 1; flip = 1; m_st = 0; end
                        else begin flip = cfg_force_tog; m_st = 2; end
                    end else m_st = 1;
                end else if (cfg_iso) begin
                    m_resp = 2; if (sz == 0) m_ur = 1; m_st = 0;
                end else begin
                    m_resp = 3; m_ur = 1; m_st = 0;
                end
            end else if (fl) m_st = 0;
            if (rel || wipe || fl) m_sofok = 0;
            else if (bus_sof && sz > 0) m_sofok = 1;
            if (fw_clr_tog) m_tog = 0; else if (flip) m_tog = ~m_tog;
            m_irq = rel && cfg_irq_en;
            if (wipe) begin
                m_len.delete(); m_dat.delete(); m_ld.delete();
            end else begin
                acc = fw_wr_en && !rdy_old && (m_ld.size() < SLOT);
                if (acc) m_ld.push_back(fw_wr_data);
                commit = !rdy_old && (fw_set_rdy || (cfg_auto_set && acc && cfg_max_units != 0
                         && m_ld.size() == int'(cfg_max_units) * 8));
                if ((rel || (fl && sz > 0)) && m_len.size() > 0) begin
                    repeat (m_len[0]) void'(m_dat.pop_front());
                    void'(m_len.pop_front());
                end
                if (commit) begin
                    m_len.push_back(m_ld.size());
                    foreach (m_ld[i]) m_dat.push_back(m_ld[i]);
                    m_ld.delete();
                end
                if (fl) m_ld.delete();
            end
        end
    end

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk_eq("R6 resp", int'(tx_resp), m_resp);
        chk_eq("R6 valid", int'(tx_valid), int'(m_st == 1));
        if (m_st == 1) begin
            chk_eq("R6 data", int'(tx_data), int'(m_dat[m_pos]));
            chk_eq("R6 last", int'(tx_last), int'(m_pos == m_cur - 1));
        end
        chk_eq("R12 pid", int'(tx_pid1), int'(m_tog));
        chk_eq(cfg_dbl ? "R3 ready" : "R2 ready", int'(st_in_rdy),
               int'(cfg_dbl ? (m_len.size() == 2) : (m_len.size() == 1)));
        chk_eq("R4 present", int'(st_pkt_present), int'(m_len.size() > 0));
        chk_eq("R10 sent_stall", int'(st_sent_stall), int'(m_ss));
        chk_eq("R8 underrun", int'(st_underrun), int'(m_ur));
        chk_eq("R7 irq", int'(irq), int'(m_irq));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (cmp_on) compare();
        fw_wr_en = 0; fw_set_rdy = 0; fw_flush = 0; fw_clr_tog = 0; fw_clr_flags = 0;
        bus_in_tok = 0; bus_ack = 0; bus_sof = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr_pkt(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            fw_wr_en = 1; fw_wr_data = 8'(base + i); step();
        end
    endtask

    task automatic commit_pkt(input int n, input int base);
        wr_pkt(n, base); fw_set_rdy = 1; step();
    endtask

    task automatic tok(); bus_in_tok = 1; step(); endtask
    task automatic do_ack(); bus_ack = 1; step(); endtask

    bit finished = 0;
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1; step(); cmp_on = 1;
        // R1 reset state
        chk_eq("R1 resp", int'(tx_resp), 0);
        chk_eq("R1 ready", int'(st_in_rdy), 0);
        chk_eq("R1 present", int'(st_pkt_present), 0);
        chk_eq("R1 flags", int'({st_sent_stall, st_underrun, irq, tx_pid1, tx_valid}), 0);

        // R2 single slot bulk send with ACK
        wr_pkt(5, 8'h10);
        chk_eq("R2 not ready before commit", int'(st_in_rdy), 0);
        fw_set_rdy = 1; step();
        chk_eq("R2 ready after commit", int'(st_in_rdy), 1);
        fw_wr_en = 1; fw_wr_data = 8'hEE; step();   // dropped while ready
        tok();
        chk_eq("R6 data response", int'(tx_resp), 1);
        idle(6);
        do_ack();
        chk_eq("R7 irq after ack", int'(irq), 1);

        // R7 lost ACK -> retransmit
        commit_pkt(3, 8'h20);
        tok(); idle(4);
        tok(); idle(4);
        do_ack(); idle(2);

        // R8 NAK with underrun, R13 clear
        tok();
        chk_eq("R8 nak", int'(tx_resp), 3);
        idle(2);
        chk_eq("R13 underrun sticky", int'(st_underrun), 1);
        fw_clr_flags = 1; step();
        chk_eq("R13 underrun cleared", int'(st_underrun), 0);

        // R3 double buffering
        cfg_dbl = 1; step();
        commit_pkt(4, 8'h30);
        chk_eq("R3 one held, not ready", int'(st_in_rdy), 0);
        commit_pkt(2, 8'h40);
        chk_eq("R3 two held, ready", int'(st_in_rdy), 1);
        tok(); idle(5); do_ack();
        tok(); idle(3); do_ack(); idle(1);

        // R11 two flushes empty two packets
        commit_pkt(3, 8'h50);
        commit_pkt(3, 8'h60);
        fw_flush = 1; step();
        chk_eq("R11 one left", int'(st_pkt_present), 1);
        fw_flush = 1; step();
        chk_eq("R11 empty", int'(st_pkt_present), 0);
        cfg_dbl = 0; step();

        // R5 auto commit at 8 bytes
        cfg_auto_set = 1; cfg_max_units = 8'd1;
        wr_pkt(7, 8'h70);
        chk_eq("R5 not yet at 7", int'(st_in_rdy), 0);
        wr_pkt(1, 8'h77);
        chk_eq("R5 auto ready at 8", int'(st_in_rdy), 1);
        tok(); idle(9); do_ack();
        wr_pkt(3, 8'h80);
        chk_eq("R5 short waits", int'(st_in_rdy), 0);
        fw_set_rdy = 1; step();
        tok(); idle(4); do_ack();
        cfg_auto_set = 0;

        // R8 isochronous
        cfg_iso = 1; step();
        tok();
        chk_eq("R8 iso zlp", int'(tx_resp), 2);
        fw_clr_flags = 1; step();
        commit_pkt(3, 8'h90);
        tok(); idle(4);
        chk_eq("R8 iso released without ack", int'(st_pkt_present), 0);

        // R9 wait for SOF
        cfg_wait_sof = 1;
        commit_pkt(2, 8'hA0);
        tok();
        chk_eq("R9 zlp before sof", int'(tx_resp), 2);
        chk_eq("R9 no underrun", int'(st_underrun), 0);
        bus_sof = 1; step();
        tok();
        chk_eq("R9 data after sof", int'(tx_resp), 1);
        idle(4);
        cfg_wait_sof = 0; cfg_iso = 0; step();

        // R10 stall
        commit_pkt(3, 8'hB0);
        cfg_send_stall = 1;
        tok();
        chk_eq("R10 stall resp", int'(tx_resp), 4);
        chk_eq("R10 flushed", int'(st_pkt_present), 0);
        chk_eq("R10 sent_stall", int'(st_sent_stall), 1);
        cfg_send_stall = 0;
        fw_clr_flags = 1; step();

        // R12 clear and forced toggle
        fw_clr_tog = 1; step();
        chk_eq("R12 cleared", int'(tx_pid1), 0);
        cfg_force_tog = 1;
        commit_pkt(2, 8'hC0);
        tok(); idle(3);
        chk_eq("R12 forced flip before ack", int'(tx_pid1), 1);
        do_ack(); idle(1);
        cfg_force_tog = 0;

        // R6 zero-length firmware packet
        fw_set_rdy = 1; step();
        tok();
        chk_eq("R6 zero-length data resp", int'(tx_resp), 1);
        chk_eq("R6 zero-length no bytes", int'(tx_valid), 0);
        do_ack(); idle(2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule